// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen 32-bit general registers of a processor core and banks part of them per processor mode. The fast-interrupt mode has private copies of registers 8 to 14. The interrupt, supervisor, abort and undefined modes each have private copies of registers 13 (stack pointer) and 14 (link register). User and system modes share one set. Registers 0 to 7 and register 15 (program counter) are common to all modes.

Two combinational read ports and one write port always address the registers visible in the current mode. A mode-change request carries a 5-bit target mode. The change takes effect at the next clock edge, and from then on the reads and writes see the incoming mode's copies. The outgoing mode's values are kept for its next entry.

Each of the five exception modes also owns a saved-status register, read and written through a dedicated port that follows the current mode. In user or system mode that port shows the live status word supplied from outside, and writes to it are dropped.

Top module: `banked_regfile`

## Requirements
- R1: Synchronous active-low reset puts the block in supervisor mode (5'b10011), clears every register copy and every saved-status register to zero.
- R2: A write with `wr_en` high updates the addressed visible register at the clock edge. Both read ports return the visible register combinationally. Registers 0 to 7 and 15 are one shared copy seen by every mode.
- R3: Fast-interrupt mode (5'b10001) has its own registers 8 to 14. Writes to them in that mode do not alter the copies seen by any other mode, and the reverse also holds.
- R4: Interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) modes each have private registers 13 and 14. Registers 8 to 12 in those modes are the user-mode copies.
- R5: User (5'b10000) and system (5'b11111) modes see the same registers 8 to 14.
- R6: A mode-change request to a legal encoding sets `cur_mode` to the target at the next edge. Without a request, the mode holds. A request for the current mode changes nothing.
- R7: A mode-change request naming an encoding outside the seven legal ones is ignored, and the mode always stays legal.
- R8: A register write in the same cycle as a mode change lands in the outgoing mode's copy.
- R9: Each of the five exception modes has its own saved-status register. It is written through `saved_wr_en` at the edge and is read back on `saved_rd_data` while that mode is current.
- R10: In user or system mode, `saved_rd_data` equals `status_live`, and saved-status writes change no saved-status register.
- R11: A saved-status write in the same cycle as a mode change lands in the outgoing mode's register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_addr_a | input | 4 | Read port A register index |
| rd_data_a | output | XLEN | Read port A data, visible copy |
| rd_addr_b | input | 4 | Read port B register index |
| rd_data_b | output | XLEN | Read port B data, visible copy |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register write index |
| wr_data | input | XLEN | Register write data |
| mode_chg | input | 1 | Mode-change request |
| mode_target | input | 5 | Requested mode encoding |
| cur_mode | output | 5 | Current mode encoding |
| status_live | input | XLEN | Live status word, shown on the saved-status port in user/system mode |
| saved_wr_en | input | 1 | Saved-status write enable |
| saved_wr_data | input | XLEN | Saved-status write data |
| saved_rd_data | output | XLEN | Saved-status read data for the current mode |

## Verification
The bench builds the block with the default data width of 32, so data patterns with the top bit set reach every copy. The bank layout is fixed by the mode set and needs no scaling. The reference model moves register values between a visible set and per-mode stores on each mode change. This checks the indexed storage of the design against a different formulation. The directed passes walk every mode pair that exposes sharing, such as supervisor followed by fast-interrupt, where a naive copy scheme loses the user registers 8 to 12. A long random phase then mixes writes, illegal targets and simultaneous write/mode-change cycles.

// File: rtl/bankrf_pkg.sv
`timescale 1ns/1ps
// Package: mode and bank encodings, and the physical layout of the banked
// register storage. Assumes sixteen architectural registers with the
// program counter at the top index.
package bankrf_pkg;

    typedef enum logic [4:0] {
        MD_USER   = 5'b10000,
        MD_FAST   = 5'b10001,
        MD_IRQ    = 5'b10010,
        MD_SVC    = 5'b10011,
        MD_ABORT  = 5'b10111,
        MD_UNDEF  = 5'b11011,
        MD_SYSTEM = 5'b11111
    } mode_e;

    // Bank owners; order of the four short banks sets their storage offset.
    typedef enum logic [2:0] {
        BK_SHARED = 3'd0,
        BK_FAST   = 3'd1,
        BK_IRQ    = 3'd2,
        BK_SVC    = 3'd3,
        BK_ABORT  = 3'd4,
        BK_UNDEF  = 3'd5
    } bank_e;

    localparam int ARCH_REGS   = 16;
    localparam int AIDX_W      = $clog2(ARCH_REGS);
    localparam int MODE_W      = 5;
    localparam int FAST_LO     = 8;
    localparam int PRIV_LO     = 13;
    localparam int PC_IDX      = ARCH_REGS - 1;
    localparam int FAST_COUNT  = PC_IDX - FAST_LO;
    localparam int PRIV_COUNT  = PC_IDX - PRIV_LO;
    localparam int NUM_SHORT   = 4;
    localparam int SAVED_BANKS = NUM_SHORT + 1;
    localparam int FAST_BASE   = ARCH_REGS;
    localparam int PRIV_BASE   = FAST_BASE + FAST_COUNT;
    localparam int PHYS_REGS   = PRIV_BASE + NUM_SHORT * PRIV_COUNT;
    localparam int PHYS_W      = $clog2(PHYS_REGS);

    // True for the seven defined mode encodings.
    function automatic logic mode_legal(input logic [MODE_W-1:0] m);
        case (m)
            MD_USER, MD_FAST, MD_IRQ, MD_SVC,
            MD_ABORT, MD_UNDEF, MD_SYSTEM: return 1'b1;
            default:                       return 1'b0;
        endcase
    endfunction

    // Bank owning the banked registers of a mode.
    function automatic bank_e mode_to_bank(input logic [MODE_W-1:0] m);
        case (m)
            MD_FAST:  return BK_FAST;
            MD_IRQ:   return BK_IRQ;
            MD_SVC:   return BK_SVC;
            MD_ABORT: return BK_ABORT;
            MD_UNDEF: return BK_UNDEF;
            default:  return BK_SHARED;
        endcase
    endfunction

endpackage

// File: rtl/bankrf_mode.sv
`timescale 1ns/1ps
// Mode register: holds the current mode, accepts legal change requests
// and reports the owning bank. Assumes requests arrive one per cycle at
// most; illegal encodings are dropped so the mode is always legal.
module bankrf_mode
    import bankrf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chg_req,
    input  logic [MODE_W-1:0] chg_target,
    output logic [MODE_W-1:0] mode_q,
    output bank_e             bank
);

    // Mode state: reset to supervisor, follow legal requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MD_SVC;
        end else if (chg_req && mode_legal(chg_target)) begin
            mode_q <= chg_target;
        end
    end

    // Bank decode of the current mode.
    assign bank = mode_to_bank(mode_q);

endmodule

// File: rtl/bankrf_map.sv
`timescale 1ns/1ps
// Index mapper: turns an architectural register index and the current
// bank into a physical storage index. Layout: 0..15 user view, then the
// fast bank's seven registers, then two per short bank.
module bankrf_map
    import bankrf_pkg::*;
(
    input  bank_e             bank,
    input  logic [AIDX_W-1:0] arch_idx,
    output logic [PHYS_W-1:0] phys_idx
);

    // Select shared, fast or short-bank storage for the index.
    always_comb begin
        int a;
        a = int'(arch_idx);
        if (a < FAST_LO || a == PC_IDX) begin
            phys_idx = PHYS_W'(a);
        end else if (bank == BK_FAST) begin
            phys_idx = PHYS_W'(FAST_BASE + a - FAST_LO);
        end else if (a < PRIV_LO || bank == BK_SHARED) begin
            phys_idx = PHYS_W'(a);
        end else begin
            phys_idx = PHYS_W'(PRIV_BASE + (int'(bank) - int'(BK_IRQ)) * PRIV_COUNT
                               + a - PRIV_LO);
        end
    end

endmodule

// File: rtl/bankrf_saved.sv
`timescale 1ns/1ps
// Saved-status store: one register per exception bank. Reads in the shared
// bank return the live status word and writes there are dropped.
// Assumes the bank input reflects the mode before any pending change.
module bankrf_saved
    import bankrf_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  bank_e           bank,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    input  logic [XLEN-1:0] live_status,
    output logic [XLEN-1:0] rd_data
);

    logic [XLEN-1:0] slot_q [SAVED_BANKS];

    // Slot update: clear on reset, write the slot of the current bank.
    always_ff @(posedge clk) begin
        for (int s = 0; s < SAVED_BANKS; s++) begin
            if (!rst_n) begin
                slot_q[s] <= '0;
            end else if (wr_en && bank == bank_e'(s + 1)) begin
                slot_q[s] <= wr_data;
            end
        end
    end

    // Read mux: live status unless an exception bank owns a slot.
    always_comb begin
        rd_data = live_status;
        for (int s = 0; s < SAVED_BANKS; s++) begin
            if (bank == bank_e'(s + 1)) begin
                rd_data = slot_q[s];
            end
        end
    end

endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
// Mode-banked register file top: sixteen visible registers over a flat
// physical store holding every banked copy, two read ports, one write
// port, mode register and saved-status store. A mode change only moves
// the index mapping, so it completes in one edge with no data copy.
module banked_regfile
    import bankrf_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_addr_a,
    output logic [XLEN-1:0]   rd_data_a,
    input  logic [3:0]        rd_addr_b,
    output logic [XLEN-1:0]   rd_data_b,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [XLEN-1:0]   wr_data,
    input  logic              mode_chg,
    input  logic [4:0]        mode_target,
    output logic [4:0]        cur_mode,
    input  logic [XLEN-1:0]   status_live,
    input  logic              saved_wr_en,
    input  logic [XLEN-1:0]   saved_wr_data,
    output logic [XLEN-1:0]   saved_rd_data
);

    localparam int NUM_PORTS = 3;

    bank_e             cur_bank;
    logic [XLEN-1:0]   phys_q   [PHYS_REGS];
    logic [AIDX_W-1:0] map_in   [NUM_PORTS];
    logic [PHYS_W-1:0] map_out  [NUM_PORTS];

    bankrf_mode u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .chg_req    (mode_chg),
        .chg_target (mode_target),
        .mode_q     (cur_mode),
        .bank       (cur_bank)
    );

    assign map_in[0] = rd_addr_a;
    assign map_in[1] = rd_addr_b;
    assign map_in[2] = wr_addr;

    // One index mapper per port, all driven by the pre-edge bank.
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_map
        bankrf_map u_map (
            .bank     (cur_bank),
            .arch_idx (map_in[g]),
            .phys_idx (map_out[g])
        );
    end

    // Physical store: clear on reset, write the mapped entry.
    always_ff @(posedge clk) begin
        for (int p = 0; p < PHYS_REGS; p++) begin
            if (!rst_n) begin
                phys_q[p] <= '0;
            end else if (wr_en && map_out[2] == PHYS_W'(p)) begin
                phys_q[p] <= wr_data;
            end
        end
    end

    assign rd_data_a = phys_q[map_out[0]];
    assign rd_data_b = phys_q[map_out[1]];

    bankrf_saved #(.XLEN(XLEN)) u_saved (
        .clk         (clk),
        .rst_n       (rst_n),
        .bank        (cur_bank),
        .wr_en       (saved_wr_en),
        .wr_data     (saved_wr_data),
        .live_status (status_live),
        .rd_data     (saved_rd_data)
    );

endmodule

// File: rtl/banked_regfile_chk.sv
`timescale 1ns/1ps
// Checker: port-level properties of the banked register file, bound to
// every instance of the top module.
module banked_regfile_chk
    import bankrf_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3:0]      rd_addr_a,
    input logic [XLEN-1:0] rd_data_a,
    input logic [3:0]      rd_addr_b,
    input logic [XLEN-1:0] rd_data_b,
    input logic            wr_en,
    input logic [3:0]      wr_addr,
    input logic [XLEN-1:0] wr_data,
    input logic            mode_chg,
    input logic [4:0]      mode_target,
    input logic [4:0]      cur_mode,
    input logic [XLEN-1:0] status_live,
    input logic            saved_wr_en,
    input logic [XLEN-1:0] saved_wr_data,
    input logic [XLEN-1:0] saved_rd_data
);

    logic in_shared;
    assign in_shared = (cur_mode == MD_USER) || (cur_mode == MD_SYSTEM);

    assert_reset_mode_R1: assert property (@(posedge clk)
        !rst_n |=> cur_mode == MD_SVC);

    assert_write_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !mode_chg |=>
            (rd_addr_a != $past(wr_addr)) || (rd_data_a == $past(wr_data)));

    assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_chg |=> $stable(cur_mode));

    assert_mode_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg && mode_legal(mode_target) |=> cur_mode == $past(mode_target));

    assert_bad_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg && !mode_legal(mode_target) |=> $stable(cur_mode));

    assert_mode_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_legal(cur_mode));

    assert_saved_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        saved_wr_en && !mode_chg && !in_shared |=>
            saved_rd_data == $past(saved_wr_data));

    assert_saved_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_shared |-> saved_rd_data == status_live);

endmodule

bind banked_regfile banked_regfile_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
// Bench: scripted and random stimulus against a swap-based reference
// model, compared on every cycle.
module sim_banked_regfile;

    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      rd_a = '0, rd_b = '0, wa = '0;
    logic            we = 1'b0, mc = 1'b0, swe = 1'b0;
    logic [XLEN-1:0] wd = '0, cs = '0, swd = '0;
    logic [4:0]      mt = 5'b10000;
    logic [XLEN-1:0] rd_data_a, rd_data_b, saved_rd_data;
    logic [4:0]      cur_mode;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    banked_regfile #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_a(rd_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_b), .rd_data_b(rd_data_b),
        .wr_en(we), .wr_addr(wa), .wr_data(wd),
        .mode_chg(mc), .mode_target(mt), .cur_mode(cur_mode),
        .status_live(cs), .saved_wr_en(swe), .saved_wr_data(swd),
        .saved_rd_data(saved_rd_data)
    );

    // Reference model: visible set plus per-owner stores, swapped on change.
    bit [XLEN-1:0] vis [16];
    bit [XLEN-1:0] store [int];
    bit [XLEN-1:0] msaved [int];
    bit [4:0]      mmode;

    function automatic int owner_bank(bit [4:0] m);
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic bit legal(bit [4:0] m);
        return m inside {5'b10000, 5'b10001, 5'b10010, 5'b10011,
                         5'b10111, 5'b11011, 5'b11111};
    endfunction

    function automatic int slot_key(bit [4:0] m, int r);
        if (r < 13) return (m == 5'b10001) ? 100 + r : r;
        return owner_bank(m) * 100 + r;
    endfunction

    function automatic bit [XLEN-1:0] store_get(int k);
        return store.exists(k) ? store[k] : '0;
    endfunction

    function automatic bit [XLEN-1:0] saved_exp();
        if (owner_bank(mmode) == 0) return cs;
        return msaved.exists(int'(mmode)) ? msaved[int'(mmode)] : '0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) vis[i] = '0;
        store.delete();
        msaved.delete();
        mmode = 5'b10011;
    endtask

    task automatic model_update();
        if (we) vis[wa] = wd;
        if (swe && owner_bank(mmode) != 0) msaved[int'(mmode)] = swd;
        if (mc && legal(mt) && mt != mmode) begin
            for (int r = 8; r < 15; r++) store[slot_key(mmode, r)] = vis[r];
            for (int r = 8; r < 15; r++) vis[r] = store_get(slot_key(mt, r));
            mmode = mt;
        end
    endtask

    task automatic check(string tag, string what, logic [XLEN-1:0] act,
                         logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        check(tag, "rd_data_a", rd_data_a, vis[rd_a]);
        check(tag, "rd_data_b", rd_data_b, vis[rd_b]);
        check(tag, "cur_mode", XLEN'(cur_mode), XLEN'(mmode));
        check(tag, "saved_rd_data", saved_rd_data, saved_exp());
    endtask

    // One cycle: compare at mid-cycle, advance the model with the edge.
    task automatic step(string tag);
        #1;
        compare(tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle();
        we = 0; mc = 0; swe = 0;
    endtask

    task automatic write_reg(int idx, logic [XLEN-1:0] val, string tag);
        we = 1; wa = 4'(idx); wd = val; rd_a = 4'(idx); rd_b = 4'(15 - idx);
        step(tag);
        idle();
    endtask

    task automatic change_mode(logic [4:0] m, string tag);
        mc = 1; mt = m;
        step(tag);
        idle();
    endtask

    task automatic read_all(string tag);
        for (int i = 0; i < 16; i++) begin
            rd_a = 4'(i); rd_b = 4'(15 - i);
            step(tag);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        for (int n = 0; n < 150000 && !done; n++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [4:0] short_modes [4];
        short_modes = '{5'b10010, 5'b10111, 5'b11011, 5'b10011};
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset state in supervisor mode.
        read_all("R1");

        // R2: write and read back every register.
        for (int i = 0; i < 16; i++) write_reg(i, 32'h8100_0000 + i, "R2");
        read_all("R2");

        // R4: supervisor's registers 8..12 are the user copies.
        change_mode(5'b10000, "R6");
        read_all("R4");
        for (int i = 0; i < 16; i++) write_reg(i, 32'h2200_0000 + i, "R2");
        read_all("R2");

        // R3: fast-interrupt bank is private for 8..14.
        change_mode(5'b10001, "R3");
        read_all("R3");
        for (int i = 8; i < 15; i++) write_reg(i, 32'hF300_0000 + i, "R3");
        write_reg(3, 32'h3333_0003, "R2");
        read_all("R3");
        change_mode(5'b10000, "R3");
        read_all("R3");

        // R4: short banks own 13 and 14 only.
        foreach (short_modes[k]) begin
            change_mode(short_modes[k], "R4");
            write_reg(13, 32'h4400_0000 + k * 16, "R4");
            write_reg(14, 32'h4500_0000 + k * 16, "R4");
            write_reg(10, 32'h4600_0000 + k, "R4");
            read_all("R4");
        end
        change_mode(5'b10001, "R3");
        read_all("R3");
        foreach (short_modes[k]) begin
            change_mode(short_modes[k], "R4");
            read_all("R4");
        end

        // R5: user and system share the bank.
        change_mode(5'b11111, "R5");
        read_all("R5");
        write_reg(13, 32'h5500_0013, "R5");
        write_reg(9, 32'h5500_0009, "R5");
        change_mode(5'b10000, "R5");
        read_all("R5");

        // R6: request for the current mode changes nothing.
        change_mode(5'b10000, "R6");
        read_all("R6");

        // R7: illegal targets are ignored.
        change_mode(5'b10100, "R7");
        change_mode(5'b00000, "R7");
        change_mode(5'b01111, "R7");
        read_all("R7");

        // R8: write with a mode change hits the outgoing copy.
        we = 1; wa = 4'd13; wd = 32'h8888_0013; mc = 1; mt = 5'b10001;
        step("R8");
        idle();
        read_all("R8");
        change_mode(5'b10000, "R8");
        read_all("R8");

        // R9: every exception mode owns its saved status.
        foreach (short_modes[k]) begin
            change_mode(short_modes[k], "R9");
            swe = 1; swd = 32'h9900_0000 + k;
            step("R9");
            idle();
            step("R9");
        end
        change_mode(5'b10001, "R9");
        swe = 1; swd = 32'h99FF_0001;
        step("R9");
        idle();
        foreach (short_modes[k]) begin
            change_mode(short_modes[k], "R9");
            step("R9");
        end

        // R10: user/system show live status; writes dropped.
        change_mode(5'b10000, "R10");
        cs = 32'hA5A5_1010;
        swe = 1; swd = 32'hDEAD_0010;
        step("R10");
        idle();
        change_mode(5'b11111, "R10");
        swe = 1; swd = 32'hDEAD_0011;
        step("R10");
        idle();
        foreach (short_modes[k]) begin
            change_mode(short_modes[k], "R10");
            step("R10");
        end

        // R11: saved write with a mode change hits the outgoing slot.
        change_mode(5'b10010, "R11");
        swe = 1; swd = 32'hB011_0011; mc = 1; mt = 5'b10001;
        step("R11");
        idle();
        step("R11");
        change_mode(5'b10010, "R11");
        step("R11");

        // Random mix of writes, mode changes and saved-status traffic.
        for (int n = 0; n < 4000; n++) begin
            logic [4:0] legal_set [7];
            legal_set = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                          5'b10111, 5'b11011, 5'b11111};
            rd_a = 4'($urandom); rd_b = 4'($urandom);
            we = 1'($urandom); wa = 4'($urandom); wd = $urandom;
            mc = ($urandom % 4) == 0;
            mt = (($urandom % 8) == 0) ? 5'($urandom) : legal_set[$urandom % 7];
            swe = 1'($urandom); swd = $urandom; cs = $urandom;
            step("R2");
        end
        idle();
        read_all("R2");

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule